// File: doc/BRIEF.md
# Flash Write-Status Output Generator

This block produces the bit-7 status value that a parallel NOR flash returns on host reads while an internal program or erase runs, together with a ready/busy level. It receives already-decoded internal events: a program start carrying the target address and the data bit being written to bit 7, an erase start carrying a sector-select mask, erase suspend and resume requests, and a completion strobe from the cell-programming engine. A static protection map marks which sectors refuse modification. Host reads arrive as a one-cycle read strobe with an address, and the array's own stored bit 7 for that address is supplied alongside so that the block can pass it through when no status applies.

Commands aimed at protected sectors do not wait for a completion strobe: the block holds a fixed busy window measured by a counter sized from the clock frequency, then returns to the mode it came from. The block also flags the first read after any operation ends, because on that read only bit 7 is already true data while the lower seven bits have not yet settled.

The address space is split into `NSECT` equal sectors; the sector index is the top `log2(NSECT)` address bits.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `ready` is 1, `rd_vld` is 0 and the block is in read mode.
- R2: A read strobe sampled on a clock edge yields `rd_vld`, `rd_dq7` and `rd_low_ok` on the next cycle; the result reflects the mode held before any command or completion accepted on that same edge, so status becomes valid only after the edge that accepts the command.
- R3: A program to an unprotected sector drives `ready` low from the next cycle until `op_done`; meanwhile a read at exactly the target address returns the inverse of the programmed bit, and reads at other addresses return `arr_bit`. After completion the target address returns `arr_bit`.
- R4: An erase drives `ready` low until `op_done`; reads in an erased sector return 0 and reads in any other sector return 1.
- R5: `susp_req` during an erase puts the block in suspend: `ready` rises, reads in erased sectors return 1, other reads return `arr_bit`. `resume_req` returns to the erase (`ready` low, erased sectors read 0).
- R6: A program issued while suspended drives `ready` low, shows the inverted bit at its address, returns 1 in the suspended erase's sectors, and on `op_done` returns to suspend rather than to read mode.
- R7: A program whose target sector is protected holds `ready` low for exactly `CLK_MHZ` cycles (1 us) with the inverted bit at the target address, then returns to the mode it was issued from without waiting for `op_done`.
- R8: An erase whose selected sectors are all protected holds `ready` low for exactly `100*CLK_MHZ` cycles (100 us), with those sectors reading 0, then returns to read mode.
- R9: An erase with only some selected sectors protected erases the unprotected ones: protected sectors read as outside the erase (1), and the block waits for `op_done` however long that takes.
- R10: `rd_low_ok` is 1 only for reads whose bit 7 comes from `arr_bit`, and is 0 on the first read after any program, erase or protected window ends.
- R11: `op_done` wins over `susp_req`; `prog_go` wins over `erase_go` and over `resume_req`; commands arriving while `ready` is low, and an erase with an empty mask, are ignored.
- R12: In read mode a read returns `arr_bit` with `rd_low_ok` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_go | input | 1 | Program start strobe |
| prog_addr | input | AW | Program target address |
| prog_bit | input | 1 | Data bit being programmed into bit 7 |
| erase_go | input | 1 | Erase start strobe |
| erase_sel | input | NSECT | Sectors selected for erase |
| prot_map | input | NSECT | Protected sectors |
| susp_req | input | 1 | Erase suspend request |
| resume_req | input | 1 | Erase resume request |
| op_done | input | 1 | Completion strobe from the programming engine |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | AW | Host read address |
| arr_bit | input | 1 | Stored bit 7 at the read address |
| rd_dq7 | output | 1 | Bit 7 returned to the host |
| rd_vld | output | 1 | Read result valid |
| rd_low_ok | output | 1 | Bits 0 to 6 of this read hold valid data |
| ready | output | 1 | High when no operation or busy window runs |

## Verification
A host read and the completion of an operation can land on the same clock edge, as can a read and the command that starts an operation. The bench provokes both by raising `rd_en` in the same cycle as `op_done` or `prog_go`; the scoreboard expects the read to report the earlier mode (status for the completion case, array data for the start case) and expects the following read to carry `rd_low_ok` = 0. Suspend and completion arriving together are also driven, and read mode is expected.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_ESUSP,
    ST_SPROG,
    ST_PPROT,
    ST_EPROT
  } fsg_state_e;

  function automatic logic st_busy(input fsg_state_e s);
    case (s)
      ST_PROG, ST_ERASE, ST_SPROG, ST_PPROT, ST_EPROT: st_busy = 1'b1;
      default:                                         st_busy = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fsg_region.sv
module fsg_region #(
  parameter int AW    = 16,
  parameter int NSECT = 8
) (
  input  logic [AW-1:0]    addr,
  input  logic [NSECT-1:0] mask,
  output logic             hit
);
  localparam int SW = $clog2(NSECT);

  logic [SW-1:0]    sect;
  logic [NSECT-1:0] dec;

  assign sect = addr[AW-1 -: SW];

  for (genvar s = 0; s < NSECT; s++) begin : g_dec
    assign dec[s] = (sect == SW'(s)) && mask[s];
  end

  assign hit = |dec;
endmodule

// File: rtl/fsg_window_timer.sv
module fsg_window_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/fsg_seq.sv
module fsg_seq
  import fsg_pkg::*;
#(
  parameter int AW        = 16,
  parameter int NSECT     = 8,
  parameter int PROG_CYC  = 10,
  parameter int ERASE_CYC = 1000,
  parameter int TW        = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prog_go,
  input  logic [AW-1:0]    prog_addr,
  input  logic             prog_bit,
  input  logic             prog_prot,
  input  logic             erase_go,
  input  logic [NSECT-1:0] erase_sel,
  input  logic [NSECT-1:0] prot_map,
  input  logic             susp_req,
  input  logic             resume_req,
  input  logic             op_done,
  input  logic             tmr_zero,
  output fsg_state_e       state,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  output logic             tmr_run,
  output logic [AW-1:0]    tgt_addr,
  output logic             tgt_bit,
  output logic [NSECT-1:0] ers_mask,
  output logic             finish
);
  fsg_state_e       nxt;
  logic             acc_p, acc_e, ret_susp;
  logic [NSECT-1:0] eff;

  assign eff = erase_sel & ~prot_map;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    acc_p    = 1'b0;
    acc_e    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (prog_go) begin
          acc_p = 1'b1;
          if (prog_prot) begin
            nxt = ST_PPROT; tmr_load = 1'b1; tmr_val = TW'(PROG_CYC - 1);
          end else begin
            nxt = ST_PROG;
          end
        end else if (erase_go && (erase_sel != '0)) begin
          acc_e = 1'b1;
          if (eff == '0) begin
            nxt = ST_EPROT; tmr_load = 1'b1; tmr_val = TW'(ERASE_CYC - 1);
          end else begin
            nxt = ST_ERASE;
          end
        end
      end
      ST_PROG:  if (op_done) nxt = ST_IDLE;
      ST_ERASE: begin
        if (op_done)       nxt = ST_IDLE;
        else if (susp_req) nxt = ST_ESUSP;
      end
      ST_ESUSP: begin
        if (prog_go) begin
          acc_p = 1'b1;
          if (prog_prot) begin
            nxt = ST_PPROT; tmr_load = 1'b1; tmr_val = TW'(PROG_CYC - 1);
          end else begin
            nxt = ST_SPROG;
          end
        end else if (resume_req) begin
          nxt = ST_ERASE;
        end
      end
      ST_SPROG: if (op_done)  nxt = ST_ESUSP;
      ST_PPROT: if (tmr_zero) nxt = ret_susp ? ST_ESUSP : ST_IDLE;
      ST_EPROT: if (tmr_zero) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign tmr_run = (state == ST_PPROT) || (state == ST_EPROT);
  assign finish  = st_busy(state) && !st_busy(nxt) &&
                   !((state == ST_ERASE) && (nxt == ST_ESUSP));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tgt_addr <= '0;
      tgt_bit  <= 1'b0;
      ret_susp <= 1'b0;
      ers_mask <= '0;
    end else begin
      state <= nxt;
      if (acc_p) begin
        tgt_addr <= prog_addr;
        tgt_bit  <= prog_bit;
        ret_susp <= (state == ST_ESUSP);
      end
      if (acc_e) ers_mask <= (eff == '0) ? erase_sel : eff;
    end
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int AW      = 16,
  parameter int NSECT   = 8,
  parameter int CLK_MHZ = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prog_go,
  input  logic [AW-1:0]    prog_addr,
  input  logic             prog_bit,
  input  logic             erase_go,
  input  logic [NSECT-1:0] erase_sel,
  input  logic [NSECT-1:0] prot_map,
  input  logic             susp_req,
  input  logic             resume_req,
  input  logic             op_done,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             arr_bit,
  output logic             rd_dq7,
  output logic             rd_vld,
  output logic             rd_low_ok,
  output logic             ready
);
  localparam int PROG_CYC  = CLK_MHZ;
  localparam int ERASE_CYC = 100 * CLK_MHZ;
  localparam int TW        = $clog2(ERASE_CYC + 1);

  fsg_state_e       state;
  logic             tmr_load, tmr_run, tmr_zero, finish;
  logic [TW-1:0]    tmr_val;
  logic [AW-1:0]    tgt_addr;
  logic             tgt_bit, prog_prot, in_ers, hit_tgt, settle;
  logic [NSECT-1:0] ers_mask;
  logic             st_dq7, from_arr;

  fsg_region #(.AW(AW), .NSECT(NSECT)) u_prot_lu (
    .addr(prog_addr), .mask(prot_map), .hit(prog_prot)
  );

  fsg_region #(.AW(AW), .NSECT(NSECT)) u_ers_lu (
    .addr(rd_addr), .mask(ers_mask), .hit(in_ers)
  );

  fsg_window_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .run(tmr_run), .zero(tmr_zero)
  );

  fsg_seq #(
    .AW(AW), .NSECT(NSECT), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .TW(TW)
  ) u_seq (
    .clk(clk), .rst(rst),
    .prog_go(prog_go), .prog_addr(prog_addr), .prog_bit(prog_bit),
    .prog_prot(prog_prot), .erase_go(erase_go), .erase_sel(erase_sel),
    .prot_map(prot_map), .susp_req(susp_req), .resume_req(resume_req),
    .op_done(op_done), .tmr_zero(tmr_zero), .state(state),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_run(tmr_run),
    .tgt_addr(tgt_addr), .tgt_bit(tgt_bit), .ers_mask(ers_mask),
    .finish(finish)
  );

  assign hit_tgt = (rd_addr == tgt_addr);
  assign ready   = !st_busy(state);

  // Bit-7 source for the read presented this cycle
  always_comb begin
    st_dq7   = arr_bit;
    from_arr = 1'b1;
    case (state)
      ST_PROG, ST_PPROT: begin
        if (hit_tgt) begin st_dq7 = ~tgt_bit; from_arr = 1'b0; end
      end
      ST_SPROG: begin
        if (hit_tgt)     begin st_dq7 = ~tgt_bit; from_arr = 1'b0; end
        else if (in_ers) begin st_dq7 = 1'b1;     from_arr = 1'b0; end
      end
      ST_ERASE, ST_EPROT: begin
        st_dq7 = ~in_ers; from_arr = 1'b0;
      end
      ST_ESUSP: begin
        if (in_ers) begin st_dq7 = 1'b1; from_arr = 1'b0; end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld    <= 1'b0;
      rd_dq7    <= 1'b0;
      rd_low_ok <= 1'b0;
      settle    <= 1'b0;
    end else begin
      rd_vld    <= rd_en;
      rd_dq7    <= rd_en ? st_dq7 : 1'b0;
      rd_low_ok <= rd_en && from_arr && !settle;
      if (finish)     settle <= 1'b1;
      else if (rd_en) settle <= 1'b0;
    end
  end
endmodule

// File: rtl/fsg_chk.sv
module fsg_chk #(
  parameter int AW      = 16,
  parameter int NSECT   = 8,
  parameter int CLK_MHZ = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             prog_go,
  input logic [AW-1:0]    prog_addr,
  input logic             erase_go,
  input logic [NSECT-1:0] erase_sel,
  input logic [NSECT-1:0] prot_map,
  input logic             rd_en,
  input logic             rd_vld,
  input logic             rd_low_ok,
  input logic             ready
);
  localparam int SW = $clog2(NSECT);

  logic p_prot, e_allprot;
  logic pp_on, ep_on;
  int   pp_cnt, ep_cnt;

  assign p_prot    = prot_map[prog_addr[AW-1 -: SW]];
  assign e_allprot = (erase_sel != '0) && ((erase_sel & ~prot_map) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_on <= 1'b0; pp_cnt <= 0;
      ep_on <= 1'b0; ep_cnt <= 0;
    end else begin
      if (ready && prog_go && p_prot) begin
        pp_on <= 1'b1; pp_cnt <= 0;
      end else if (pp_on && ready) begin
        pp_on <= 1'b0;
      end else if (pp_on) begin
        pp_cnt <= pp_cnt + 1;
      end
      if (ready && !prog_go && erase_go && e_allprot) begin
        ep_on <= 1'b1; ep_cnt <= 0;
      end else if (ep_on && ready) begin
        ep_on <= 1'b0;
      end else if (ep_on) begin
        ep_cnt <= ep_cnt + 1;
      end
    end
  end

  // R7
  prot_prog_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ready) && pp_on) |-> (pp_cnt == CLK_MHZ));

  // R8
  prot_erase_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ready) && ep_on) |-> (ep_cnt == 100 * CLK_MHZ));

  // R2
  read_resp_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_vld);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_vld);

  // R10
  low_ok_with_vld_chk: assert property (@(posedge clk) disable iff (rst)
    rd_low_ok |-> rd_vld);

  // R3
  prog_goes_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && prog_go && !p_prot) |=> !ready);
endmodule

bind flash_status_gen fsg_chk #(
  .AW(AW), .NSECT(NSECT), .CLK_MHZ(CLK_MHZ)
) chk_i (
  .clk(clk), .rst(rst), .prog_go(prog_go), .prog_addr(prog_addr),
  .erase_go(erase_go), .erase_sel(erase_sel), .prot_map(prot_map),
  .rd_en(rd_en), .rd_vld(rd_vld), .rd_low_ok(rd_low_ok), .ready(ready)
);

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 16;
  localparam int NSECT      = 8;
  localparam int CLK_MHZ    = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             prog_go = 1'b0, prog_bit = 1'b0;
  logic [AW-1:0]    prog_addr = '0;
  logic             erase_go = 1'b0;
  logic [NSECT-1:0] erase_sel = '0;
  logic [NSECT-1:0] prot_map = 8'b1000_0100;
  logic             susp_req = 1'b0, resume_req = 1'b0, op_done = 1'b0;
  logic             rd_en = 1'b0, arr_bit = 1'b0;
  logic [AW-1:0]    rd_addr = '0;
  logic             rd_dq7, rd_vld, rd_low_ok, ready;

  int vec = 0, bad = 0;
  bit finished = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(.AW(AW), .NSECT(NSECT), .CLK_MHZ(CLK_MHZ)) dut_i (
    .clk(clk), .rst(rst), .prog_go(prog_go), .prog_addr(prog_addr),
    .prog_bit(prog_bit), .erase_go(erase_go), .erase_sel(erase_sel),
    .prot_map(prot_map), .susp_req(susp_req), .resume_req(resume_req),
    .op_done(op_done), .rd_en(rd_en), .rd_addr(rd_addr), .arr_bit(arr_bit),
    .rd_dq7(rd_dq7), .rd_vld(rd_vld), .rd_low_ok(rd_low_ok), .ready(ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ready(input logic e, input string tag);
    chk(ready === e, tag, int'(ready), int'(e));
  endtask

  // Driver: one-cycle read, expected {dq7, low_ok} pushed to the scoreboard
  task automatic rd(input logic [AW-1:0] a, input logic arr,
                    input logic e7, input logic elo, input string tag);
    rd_en = 1'b1; rd_addr = a; arr_bit = arr;
    exp_q.push_back({e7, elo}); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_prog(input logic [AW-1:0] a, input logic b);
    prog_go = 1'b1; prog_addr = a; prog_bit = b;
    @(negedge clk);
    prog_go = 1'b0;
  endtask

  task automatic pulse_erase(input logic [NSECT-1:0] s);
    erase_go = 1'b1; erase_sel = s;
    @(negedge clk);
    erase_go = 1'b0;
  endtask

  task automatic pulse_done();
    op_done = 1'b1; @(negedge clk); op_done = 1'b0;
  endtask

  // Monitor: compare each produced read against the queue front
  always @(negedge clk) begin
    if (!rst && rd_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected read result", 1, 0);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({rd_dq7, rd_low_ok} === e, t, int'({rd_dq7, rd_low_ok}), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_ready(1'b1, "R1 ready after reset");
    chk(rd_vld === 1'b0, "R1 rd_vld after reset", int'(rd_vld), 0);

    // R12 read mode
    rd(16'h0010, 1'b1, 1'b1, 1'b1, "R12 idle read 1");
    rd(16'h0010, 1'b0, 1'b0, 1'b1, "R12 idle read 0");

    // R3 program
    pulse_prog(16'h0100, 1'b1);
    chk_ready(1'b0, "R3 busy during program");
    rd(16'h0100, 1'b1, 1'b0, 1'b0, "R3 inverted bit at target");
    rd(16'h0200, 1'b1, 1'b1, 1'b1, "R3 other address array");
    pulse_done();
    chk_ready(1'b1, "R3 ready after done");
    rd(16'h0100, 1'b1, 1'b1, 1'b0, "R10 first read after done");
    rd(16'h0100, 1'b1, 1'b1, 1'b1, "R10 second read after done");

    // R2 read on the completion edge
    pulse_prog(16'h0100, 1'b0);
    op_done = 1'b1;
    rd(16'h0100, 1'b0, 1'b1, 1'b0, "R2 read with done sees status");
    op_done = 1'b0;
    rd(16'h0100, 1'b0, 1'b0, 1'b0, "R10 settle read");
    rd(16'h0100, 1'b0, 1'b0, 1'b1, "R10 settled read");

    // R2 read on the command edge
    prog_go = 1'b1; prog_addr = 16'h0100; prog_bit = 1'b0;
    rd(16'h0100, 1'b0, 1'b0, 1'b1, "R2 read with command sees array");
    prog_go = 1'b0;
    rd(16'h0100, 1'b0, 1'b1, 1'b0, "R2 status after command edge");
    pulse_done();
    rd(16'h0100, 1'b0, 1'b0, 1'b0, "R10 settle read 2");

    // R4 / R9 erase with partial protection (sectors 1,2; 2 protected)
    pulse_erase(8'b0000_0110);
    chk_ready(1'b0, "R4 busy during erase");
    rd(16'h2000, 1'b1, 1'b0, 1'b0, "R4 erased sector reads 0");
    rd(16'h4000, 1'b0, 1'b1, 1'b0, "R9 protected selected sector reads 1");
    rd(16'h6000, 1'b0, 1'b1, 1'b0, "R4 unselected sector reads 1");
    repeat (1100) @(negedge clk);
    chk_ready(1'b0, "R9 erase waits for done");
    susp_req = 1'b1; op_done = 1'b1;
    @(negedge clk);
    susp_req = 1'b0; op_done = 1'b0;
    chk_ready(1'b1, "R11 done beats suspend");
    rd(16'h2000, 1'b0, 1'b0, 1'b0, "R11 read mode after done+suspend");

    // R5 / R6 suspend and program in suspend
    pulse_erase(8'b0000_0010);
    susp_req = 1'b1; @(negedge clk); susp_req = 1'b0;
    chk_ready(1'b1, "R5 ready in suspend");
    rd(16'h2000, 1'b0, 1'b1, 1'b0, "R5 suspended sector reads 1");
    rd(16'h0000, 1'b0, 1'b0, 1'b1, "R5 other sector array");
    pulse_prog(16'h6004, 1'b1);
    chk_ready(1'b0, "R6 busy for program in suspend");
    rd(16'h6004, 1'b1, 1'b0, 1'b0, "R6 inverted bit in suspend");
    rd(16'h2000, 1'b0, 1'b1, 1'b0, "R6 erase sector reads 1");
    pulse_done();
    chk_ready(1'b1, "R6 back to suspend ready");
    rd(16'h2000, 1'b0, 1'b1, 1'b0, "R6 still suspended");
    rd(16'h6004, 1'b1, 1'b1, 1'b1, "R6 programmed address array");

    // R7 protected program from suspend
    pulse_prog(16'h4000, 1'b1);
    rd(16'h4000, 1'b1, 1'b0, 1'b0, "R7 inverted bit in window");
    cnt = 1;
    while (!ready) begin cnt++; @(negedge clk); end
    chk(cnt == CLK_MHZ, "R7 window length from suspend", cnt, CLK_MHZ);
    rd(16'h2000, 1'b0, 1'b1, 1'b0, "R7 returned to suspend");
    rd(16'h0000, 1'b1, 1'b1, 1'b1, "R7 array after window");
    resume_req = 1'b1; @(negedge clk); resume_req = 1'b0;
    chk_ready(1'b0, "R5 resume busy");
    rd(16'h2000, 1'b1, 1'b0, 1'b0, "R5 resumed erase reads 0");
    pulse_done();
    chk_ready(1'b1, "R5 erase done");
    rd(16'h2000, 1'b1, 1'b1, 1'b0, "R10 after erase");

    // R7 protected program from read mode
    pulse_prog(16'hE000, 1'b1);
    rd(16'hE000, 1'b1, 1'b0, 1'b0, "R7 inverted bit idle window");
    cnt = 1;
    while (!ready) begin cnt++; @(negedge clk); end
    chk(cnt == CLK_MHZ, "R7 window length from idle", cnt, CLK_MHZ);
    rd(16'hE000, 1'b1, 1'b1, 1'b0, "R7 read mode after window");
    rd(16'hE000, 1'b1, 1'b1, 1'b1, "R7 settled after window");

    // R8 all-protected erase, R11 command during busy ignored
    pulse_erase(8'b1000_0100);
    rd(16'h4000, 1'b1, 1'b0, 1'b0, "R8 protected erase status 0");
    cnt = 1;
    while (!ready) begin
      if (cnt == 5) begin prog_go = 1'b1; prog_addr = 16'h0100; prog_bit = 1'b1; end
      else prog_go = 1'b0;
      cnt++;
      @(negedge clk);
    end
    prog_go = 1'b0;
    chk(cnt == 100 * CLK_MHZ, "R8 window length", cnt, 100 * CLK_MHZ);
    rd(16'h0100, 1'b0, 1'b0, 1'b0, "R11 program while busy ignored");

    // R11 program beats erase on the same edge
    prog_go = 1'b1; prog_addr = 16'h0100; prog_bit = 1'b1;
    erase_go = 1'b1; erase_sel = 8'b0000_1000;
    @(negedge clk);
    prog_go = 1'b0; erase_go = 1'b0;
    rd(16'h6000, 1'b1, 1'b1, 1'b1, "R11 no erase when program wins");
    rd(16'h0100, 1'b1, 1'b0, 1'b0, "R11 program status");
    pulse_done();

    // R11 empty erase mask ignored
    pulse_erase(8'b0000_0000);
    chk_ready(1'b1, "R11 empty erase ignored");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule